// File: doc/BRIEF.md
# Three-Line Event Interrupt Aggregator

This block gathers up to 96 single-cycle event pulses from peripherals into three 32-bit sticky status words. Three interrupt request lines leave the block. Each line has its own group of three 32-bit enable words that span all 96 events, so software can send any event to any combination of lines. Line 0 is the most urgent, line 1 is the middle line and line 2 is the least urgent. A processor reads and writes every register over a plain 32-bit word bus. It acknowledges an event by writing a one to that event's status bit.

Each line also has a helper output. It gives the number of the lowest pending, enabled event on that line and a flag that says whether any such event exists. The handler can use it instead of scanning the status words.

Top module: `evtAggregator`

## Requirements
- R1: Event n (0..95) is held in status word n/32, at bit n%32. The three status words sit at byte offsets 0x00, 0x04 and 0x08.
- R2: When a pulse arrives on evtPulse[n], status bit n is set at that clock edge. The bit then stays set until software clears it, even after the pulse has gone.
- R3: Writing a 1 to a status bit clears that bit at the write edge. Writing a 0 leaves the bit unchanged.
- R4: If a pulse and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R5: The enable group for line g (g = 0..2) starts at byte offset 0x10*(g+1). Enable word w of that group is at that base + 4*w and covers status word w. Enable words are read/write and reset to zero.
- R6: irqReq[g] is registered. It is high in the cycle after some status bit and its enable bit in group g are both 1, and low in the cycle after no such pair exists. Bit 0 of irqReq is the most urgent line and bit 2 the least urgent.
- R7: Clearing an enable bit removes that event from the line. It does not change the status bit.
- R8: pendValid[g] and pendIdx[g*7 +: 7] follow the current register contents with no added delay. pendIdx gives the lowest event number whose status bit and group-g enable bit are both 1. pendValid is 1 when such an event exists.
- R9: Reset clears all status and enable words. The following addresses are unmapped: a byte address with bits [1:0] nonzero, a region other than 0 to 3, and a word index of 3. A read of an unmapped address returns zero, and a write to one changes nothing.
- R10: A read that is strobed at one clock edge returns its data on busRData after that edge. busRData keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 96 | Event pulses, one bit per event |
| busAddr | input | 8 | Byte address of the register |
| busWrEn | input | 1 | Write strobe |
| busWData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRData | output | 32 | Read data, registered |
| irqReq | output | 3 | Registered request lines; bit 0 is the most urgent |
| pendValid | output | 3 | A pending, enabled event exists on the line |
| pendIdx | output | 21 | Lowest pending, enabled event number, 7 bits per line |

## Verification
Status bits, enable words and the pending index and valid outputs change at the edge that carries the pulse or the write. The bench checks them at the falling edge that follows that edge. irqReq lags by one more register, so each request check first confirms that the line has not yet changed at that falling edge, then waits one full cycle before checking the new level. Read data is due after the edge that samples the read strobe. The driver queues the expected word when it issues the read, and the monitor compares it at the following falling edge.

// File: rtl/evtagg_pkg.sv
package evtagg_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 3;
  localparam int NUM_LINES = 3;
  localparam int ADDR_W    = 8;
  localparam int EVT_N     = WORD_W * NUM_WORDS;
  localparam int IDX_W     = $clog2(EVT_N);
  localparam int REGION_W  = ADDR_W - 4;
  localparam int GRP_N     = NUM_LINES * NUM_WORDS;

  typedef struct packed {
    logic [NUM_WORDS-1:0] clrStat;
    logic [GRP_N-1:0]     wrMask;
    logic [NUM_WORDS-1:0] rdStat;
    logic [GRP_N-1:0]     rdMask;
    logic                 rdStrobe;
  } ctrlStrobes_t;
endpackage

// File: rtl/evtagg_ctrl.sv
module evtagg_ctrl
  import evtagg_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output ctrlStrobes_t      strobes
);
  logic [REGION_W-1:0] region;
  logic [1:0]          wordSel;
  logic                aligned;

  assign region  = busAddr[ADDR_W-1:4];
  assign wordSel = busAddr[3:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    strobes          = '0;
    strobes.rdStrobe = busRdEn;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (aligned && region == '0 && wordSel == 2'(w)) begin
        strobes.clrStat[w] = busWrEn;
        strobes.rdStat[w]  = busRdEn;
      end
      for (int g = 0; g < NUM_LINES; g++) begin
        if (aligned && region == REGION_W'(g + 1) && wordSel == 2'(w)) begin
          strobes.wrMask[g*NUM_WORDS + w] = busWrEn;
          strobes.rdMask[g*NUM_WORDS + w] = busRdEn;
        end
      end
    end
  end
endmodule

// File: rtl/evtagg_datapath.sv
module evtagg_datapath
  import evtagg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [EVT_N-1:0]       evtPulse,
  input  logic [WORD_W-1:0]      busWData,
  input  ctrlStrobes_t           strobes,
  output logic [EVT_N-1:0]       statusVec,
  output logic [NUM_LINES*EVT_N-1:0] maskVec,
  output logic [WORD_W-1:0]      busRData,
  output logic [NUM_LINES-1:0]   irqReq
);
  logic [NUM_WORDS-1:0][WORD_W-1:0]                statReg;
  logic [NUM_LINES-1:0][NUM_WORDS-1:0][WORD_W-1:0] maskReg;
  logic [WORD_W-1:0]    rdMux;
  logic [NUM_LINES-1:0] hitNext;

  assign statusVec = statReg;
  assign maskVec   = maskReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= '0;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        statReg[w] <= (statReg[w] & ~(strobes.clrStat[w] ? busWData : '0))
                      | evtPulse[w*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
    end else begin
      for (int g = 0; g < NUM_LINES; g++) begin
        for (int w = 0; w < NUM_WORDS; w++) begin
          if (strobes.wrMask[g*NUM_WORDS + w]) maskReg[g][w] <= busWData;
        end
      end
    end
  end

  always_comb begin
    for (int g = 0; g < NUM_LINES; g++) begin
      hitNext[g] = |(statReg & maskReg[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqReq <= '0;
    else       irqReq <= hitNext;
  end

  always_comb begin
    rdMux = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (strobes.rdStat[w]) rdMux = rdMux | statReg[w];
      for (int g = 0; g < NUM_LINES; g++) begin
        if (strobes.rdMask[g*NUM_WORDS + w]) rdMux = rdMux | maskReg[g][w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 busRData <= '0;
    else if (strobes.rdStrobe) busRData <= rdMux;
  end
endmodule

// File: rtl/evtagg_prienc.sv
module evtagg_prienc
  import evtagg_pkg::*;
(
  input  logic [EVT_N-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             valid
);
  always_comb begin
    idx = '0;
    for (int i = EVT_N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign valid = |vec;
endmodule

// File: rtl/evtAggregator.sv
module evtAggregator
  import evtagg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [EVT_N-1:0]           evtPulse,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busWrEn,
  input  logic [WORD_W-1:0]          busWData,
  input  logic                       busRdEn,
  output logic [WORD_W-1:0]          busRData,
  output logic [NUM_LINES-1:0]       irqReq,
  output logic [NUM_LINES-1:0]       pendValid,
  output logic [NUM_LINES*IDX_W-1:0] pendIdx
);
  ctrlStrobes_t strobes;
  logic [EVT_N-1:0]           statusVec;
  logic [NUM_LINES*EVT_N-1:0] maskVec;

  evtagg_ctrl uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobes (strobes)
  );

  evtagg_datapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .evtPulse  (evtPulse),
    .busWData  (busWData),
    .strobes   (strobes),
    .statusVec (statusVec),
    .maskVec   (maskVec),
    .busRData  (busRData),
    .irqReq    (irqReq)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : gLine
    evtagg_prienc uEnc (
      .vec   (statusVec & maskVec[l*EVT_N +: EVT_N]),
      .idx   (pendIdx[l*IDX_W +: IDX_W]),
      .valid (pendValid[l])
    );
  end
endmodule

// File: rtl/evtagg_checker.sv
module evtagg_checker
  import evtagg_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic [EVT_N-1:0]           evtPulse,
  input logic                       busWrEn,
  input logic [NUM_LINES-1:0]       irqReq,
  input logic [NUM_LINES-1:0]       pendValid,
  input logic [NUM_LINES*IDX_W-1:0] pendIdx,
  input logic [EVT_N-1:0]           statusVec,
  input logic [NUM_LINES*EVT_N-1:0] maskVec
);
  logic live;
  always_ff @(posedge clk) live <= rstN;

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    live |-> ((statusVec & $past(evtPulse)) == $past(evtPulse))); // R2

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (live && !$past(busWrEn)) |-> (($past(statusVec) & ~statusVec) == '0)); // R3

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (live && !$past(busWrEn)) |-> $stable(maskVec)); // R5

  for (genvar l = 0; l < NUM_LINES; l++) begin : gChk
    logic [EVT_N-1:0] hitVec;
    logic [IDX_W-1:0] idx;
    assign hitVec = statusVec & maskVec[l*EVT_N +: EVT_N];
    assign idx    = pendIdx[l*IDX_W +: IDX_W];

    AST_IRQ_LAGS_ONE: assert property (@(posedge clk) disable iff (!rstN)
      live |-> (irqReq[l] == $past(pendValid[l]))); // R6

    AST_INDEX_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
      pendValid[l] |-> (hitVec[idx] && ((hitVec & ~({EVT_N{1'b1}} << idx)) == '0))); // R8
  end
endmodule

bind evtAggregator evtagg_checker uChk (.*);

// File: tb/evtAggregator_test.sv
module evtAggregator_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [95:0] evtPulse = '0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRData;
  logic [2:0]  irqReq;
  logic [2:0]  pendValid;
  logic [20:0] pendIdx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [95:0] mStat = '0;
  logic [95:0] mMask [3];
  logic [31:0] expQ [$];
  string       tagQ [$];
  logic        rdSeen = 1'b0;

  always #5 clk = ~clk;

  evtAggregator uut (.*);

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] expReg(input logic [7:0] a);
    if (a[1:0] != 2'b00 || a[3:2] == 2'd3) return '0;
    if (a[7:4] == 4'd0) return mStat[a[3:2]*32 +: 32];
    if (a[7:4] >= 4'd1 && a[7:4] <= 4'd3) return mMask[a[7:4]-1][a[3:2]*32 +: 32];
    return '0;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [95:0] evt = '0);
    @(negedge clk);
    busAddr = a; busWData = d; busWrEn = 1'b1; evtPulse = evt;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; evtPulse = '0;
    if (a[1:0] == 2'b00 && a[3:2] != 2'd3) begin
      if (a[7:4] == 4'd0) mStat[a[3:2]*32 +: 32] = mStat[a[3:2]*32 +: 32] & ~d;
      else if (a[7:4] <= 4'd3) mMask[a[7:4]-1][a[3:2]*32 +: 32] = d;
    end
    mStat = mStat | evt;
  endtask

  task automatic pulse(input logic [95:0] evt);
    @(negedge clk);
    evtPulse = evt;
    @(posedge clk);
    @(negedge clk);
    evtPulse = '0;
    mStat = mStat | evt;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    expQ.push_back(expReg(a));
    tagQ.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkPend(input string tag);
    for (int l = 0; l < 3; l++) begin
      logic [95:0] hit;
      logic [6:0]  low;
      hit = mStat & mMask[l];
      low = '0;
      for (int i = 95; i >= 0; i--) if (hit[i]) low = 7'(i);
      chk({31'd0, pendValid[l]}, {31'd0, |hit}, {tag, " R8 valid"});
      if (|hit) chk({25'd0, pendIdx[l*7 +: 7]}, {25'd0, low}, {tag, " R8 index"});
    end
  endtask

  task automatic checkIrq(input string tag);
    logic [2:0] e;
    for (int l = 0; l < 3; l++) e[l] = |(mStat & mMask[l]);
    chk({29'd0, irqReq}, {29'd0, e}, {tag, " R6 irq"});
  endtask

  always @(posedge clk) rdSeen <= busRdEn;

  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected read actual=%h expected=none", busRData);
      end else begin
        chk(busRData, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 3; l++) mMask[l] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R9 reset state
    chk({29'd0, irqReq}, 32'd0, "R9 reset irq");
    chk({29'd0, pendValid}, 32'd0, "R9 reset pendValid");
    for (int a = 0; a < 64; a += 4) rd(8'(a), "R9 reset register");

    // R1 R2 sticky event in word 0, masked off
    pulse(96'd1 << 5);
    idle();
    rd(8'h00, "R1 R2 status word0 bit5");
    rd(8'h04, "R1 status word1 empty");
    checkIrq("R5 nothing enabled");

    // R5 R6 enable on line 0, check one-cycle lag
    wr(8'h10, 32'd1 << 5);
    checkPend("R8 after enable");
    chk({31'd0, irqReq[0]}, 32'd0, "R6 irq not yet");
    idle();
    chk({31'd0, irqReq[0]}, 32'd1, "R6 irq one cycle later");
    rd(8'h10, "R5 enable readback");

    // R8 lowest on line 1
    pulse((96'd1 << 70) | (96'd1 << 40));
    wr(8'h24, 32'd1 << 8);
    wr(8'h28, 32'd1 << 6);
    checkPend("R8 two pending on line1");
    wr(8'h04, 32'd1 << 8);
    checkPend("R3 R8 after clearing 40");
    rd(8'h04, "R3 cleared bit");
    wr(8'h08, 32'd0);
    rd(8'h08, "R3 zero write keeps bits");
    idle();
    checkIrq("R6 lines after clears");

    // R7 disable without touching status
    wr(8'h10, 32'd0);
    checkPend("R7 line0 disabled");
    idle();
    checkIrq("R7 irq dropped");
    rd(8'h00, "R7 status still pending");

    // R4 set beats clear
    wr(8'h00, 32'd1 << 5, 96'd1 << 5);
    rd(8'h00, "R4 set wins");
    wr(8'h00, 32'd1 << 5);
    rd(8'h00, "R3 plain clear");

    // R9 unmapped accesses
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    rd(8'h40, "R9 unmapped region");
    rd(8'h1C, "R9 word index 3");
    rd(8'h11, "R9 misaligned");
    for (int a = 16; a < 64; a += 4) rd(8'(a), "R9 enables unchanged");

    // R5 R8 line 2 high events
    wr(8'h38, 32'h8000_0001);
    pulse((96'd1 << 95) | (96'd1 << 64));
    checkPend("R8 line2 two pending");
    wr(8'h08, 32'd1);
    checkPend("R8 line2 event 95");
    idle();
    checkIrq("R6 final lines");
    rd(8'h38, "R5 group2 word2");

    idle();
    idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule